// File: doc/BRIEF.md
# I2C Slave Register-Access Port

This block lets an external I2C master read and write a small internal register file. The block never drives SCL and works as a 7-bit-address slave only. Both bus lines are brought into the system clock domain through a two-stage synchronizer and are oversampled. START, repeated START and STOP are detected from the sampled lines. SDA is driven open-drain through an output-enable that pulls the line low.

A write transaction carries the address byte first. The next byte always loads an internal register pointer, and every later byte is written to the register at the pointer, which then steps by one. A read transaction returns register contents starting at the pointer, and the pointer steps after each byte. The pointer wraps through the full 8-bit range and keeps its value across transactions.

An enable input switches the port on or off. A strap input selects the slave address: either the constant 7'h5C, or the value on a 7-bit input bus. The system clock must run at least 20 times faster than SCL, so that SCL rates up to 400 kHz are handled.

Top module: `i2c_regport_slave`

## Requirements
- R1: While `if_en` is low, `sda_oe` is 0 from the next clock onward, no ACK is given and `reg_we` never pulses, whatever happens on the bus.
- R2: With `fixed_addr_sel` = 1 the slave answers to 7'h5C. With `fixed_addr_sel` = 0 it answers to the value on `addr_bus[6:0]`. The address byte carries the address in bits 7..1 and the R/W flag in bit 0 (1 = read).
- R3: The address byte is ACKed (SDA pulled low in the 9th clock) only when it matches. On a mismatch SDA stays released until the next START, and nothing is written.
- R4: In a write, the first byte after the address loads the pointer, which then appears on `reg_addr`. This byte is ACKed and produces no `reg_we` pulse.
- R5: Each later write byte produces one single-cycle `reg_we` pulse, with `reg_addr` equal to the pointer and `reg_wdata` equal to the byte. In the next cycle the pointer increments by one, wrapping from 8'hFF to 8'h00.
- R6: A read returns `reg_rdata` at the pointer, MSB first, and the pointer increments after each byte. After an ACK from the master the next byte follows. After a NACK the slave releases SDA and waits for a START.
- R7: A STOP or a repeated START returns the slave to address matching, and the pointer keeps its value.
- R8: `sda_oe` changes only while the sampled SCL is low.
- R9: Every data byte received in a matched write, including the pointer byte, is ACKed.
- R10: After reset, `sda_oe` = 0, `reg_we` = 0 and `reg_addr` = 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 20x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| if_en | input | 1 | Interface enable; low ignores the bus |
| fixed_addr_sel | input | 1 | 1: slave address 7'h5C, 0: address from `addr_bus` |
| addr_bus | input | 7 | Alternative slave address |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain) |
| reg_addr | output | 8 | Register pointer / register-file address |
| reg_wdata | output | 8 | Register write data |
| reg_we | output | 1 | Single-cycle write strobe |
| reg_rdata | input | 8 | Register read data at `reg_addr` |

## Verification
A wrong bit counter or phase state shows up on the bus within one byte: an ACK is missing or sits on the wrong clock, or a read byte comes back shifted. A bad pointer shows on `reg_addr` and in the address of the next `reg_we` pulse within the same transaction. It also shows in the first byte of the next read, so the bench checks every strobe in the cycle it occurs and checks every returned byte. A stale enable or address-match decision shows as an ACK where the bus must stay released, which the bench sees at the 9th clock of the address byte.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK
  } slv_state_t;

  typedef enum logic [1:0] {
    PH_ADDR,
    PH_PTR,
    PH_DATA
  } rx_phase_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int          W       = 2,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic clk,
  input  logic rst_ni,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  assign scl_rise = scl_s & ~scl_p;
  assign scl_fall = ~scl_s & scl_p;
  assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2c_regport_slave.sv
module i2c_regport_slave
  import i2c_slv_pkg::*;
#(
  parameter int             AW         = 7,
  parameter int             DW         = 8,
  parameter logic [AW-1:0]  FIXED_ADDR = 7'h5C,
  parameter int             SYNC_STG   = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          if_en,
  input  logic          fixed_addr_sel,
  input  logic [AW-1:0] addr_bus,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  output logic [DW-1:0] reg_addr,
  output logic [DW-1:0] reg_wdata,
  output logic          reg_we,
  input  logic [DW-1:0] reg_rdata
);
  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] LAST_BIT = CW'(DW);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ni = rst_sync[1];

  // line sampling and bus conditions
  logic [1:0] lines_s;
  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;

  i2c_line_sync #(.W(2), .STAGES(SYNC_STG), .RST_VAL(2'b11)) u_sync (
    .clk(clk), .rst_ni(rst_ni), .d({scl_i, sda_i}), .q(lines_s)
  );
  assign scl_s = lines_s[1];
  assign sda_s = lines_s[0];

  i2c_bus_events u_evt (
    .clk(clk), .rst_ni(rst_ni), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  logic [AW-1:0] own_addr;
  assign own_addr = fixed_addr_sel ? FIXED_ADDR : addr_bus;

  // state
  slv_state_t    st_q, st_n;
  rx_phase_t     ph_q, ph_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [DW-1:0] sh_q, sh_n;
  logic [DW-1:0] ptr_q, ptr_n;
  logic          rw_q, rw_n;
  logic          mack_q, mack_n;
  logic          oe_q, oe_n;
  logic          we_q, we_n;
  logic          ptr_inc;

  always_comb begin
    st_n    = st_q;
    ph_n    = ph_q;
    cnt_n   = cnt_q;
    sh_n    = sh_q;
    rw_n    = rw_q;
    mack_n  = mack_q;
    oe_n    = oe_q;
    we_n    = 1'b0;
    ptr_inc = 1'b0;
    ptr_n   = ptr_q;

    if (!if_en) begin
      st_n = ST_IDLE;
      oe_n = 1'b0;
    end else if (start_ev) begin
      st_n  = ST_RX;
      ph_n  = PH_ADDR;
      cnt_n = '0;
      oe_n  = 1'b0;
    end else if (stop_ev) begin
      st_n = ST_IDLE;
      oe_n = 1'b0;
    end else begin
      unique case (st_q)
        ST_RX: begin
          if (scl_rise) begin
            sh_n  = {sh_q[DW-2:0], sda_s};
            cnt_n = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == LAST_BIT) begin
            unique case (ph_q)
              PH_ADDR: begin
                if (sh_q[DW-1:1] == own_addr) begin
                  rw_n = sh_q[0];
                  oe_n = 1'b1;
                  st_n = ST_RX_ACK;
                end else begin
                  st_n = ST_IDLE;
                end
              end
              PH_PTR: begin
                ptr_n = sh_q;
                oe_n  = 1'b1;
                st_n  = ST_RX_ACK;
              end
              default: begin
                we_n = 1'b1;
                oe_n = 1'b1;
                st_n = ST_RX_ACK;
              end
            endcase
          end
        end
        ST_RX_ACK: begin
          if (scl_fall) begin
            if (ph_q == PH_ADDR && rw_q) begin
              sh_n  = reg_rdata;
              oe_n  = ~reg_rdata[DW-1];
              cnt_n = CW'(1);
              st_n  = ST_TX;
            end else begin
              oe_n  = 1'b0;
              cnt_n = '0;
              ph_n  = (ph_q == PH_ADDR) ? PH_PTR : PH_DATA;
              st_n  = ST_RX;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (cnt_q == LAST_BIT) begin
              oe_n    = 1'b0;
              ptr_inc = 1'b1;
              st_n    = ST_TX_ACK;
            end else begin
              oe_n  = ~sh_q[DW-2];
              sh_n  = {sh_q[DW-2:0], 1'b0};
              cnt_n = cnt_q + 1'b1;
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise) begin
            mack_n = ~sda_s;
          end else if (scl_fall) begin
            if (mack_q) begin
              sh_n  = reg_rdata;
              oe_n  = ~reg_rdata[DW-1];
              cnt_n = CW'(1);
              st_n  = ST_TX;
            end else begin
              st_n = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end

    if (we_q || ptr_inc) ptr_n = ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      ph_q   <= PH_ADDR;
      cnt_q  <= '0;
      sh_q   <= '0;
      ptr_q  <= '0;
      rw_q   <= 1'b0;
      mack_q <= 1'b0;
      oe_q   <= 1'b0;
      we_q   <= 1'b0;
    end else begin
      st_q   <= st_n;
      ph_q   <= ph_n;
      cnt_q  <= cnt_n;
      sh_q   <= sh_n;
      ptr_q  <= ptr_n;
      rw_q   <= rw_n;
      mack_q <= mack_n;
      oe_q   <= oe_n;
      we_q   <= we_n;
    end
  end

  assign sda_oe    = oe_q;
  assign reg_we    = we_q;
  assign reg_addr  = ptr_q;
  assign reg_wdata = sh_q;
endmodule

// File: rtl/i2c_regport_slave_chk.sv
module i2c_regport_slave_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_ni,
  input logic          if_en,
  input logic          scl_s,
  input logic          sda_oe,
  input logic          reg_we,
  input logic [DW-1:0] reg_addr
);
  p_release_off_r1: assert property (@(posedge clk) disable iff (!rst_ni)
    !if_en |=> !sda_oe);

  p_no_write_off_r1: assert property (@(posedge clk) disable iff (!rst_ni)
    !if_en |=> !reg_we);

  p_we_single_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    reg_we |=> !reg_we);

  p_ptr_step_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    reg_we |=> reg_addr == DW'($past(reg_addr) + 1'b1));

  p_oe_scl_low_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    (!$stable(sda_oe) && $past(if_en)) |-> !$past(scl_s));
endmodule

bind i2c_regport_slave i2c_regport_slave_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_ni(rst_ni), .if_en(if_en), .scl_s(scl_s),
  .sda_oe(sda_oe), .reg_we(reg_we), .reg_addr(reg_addr)
);

// File: tb/i2c_regport_slave_test.sv
module i2c_regport_slave_test;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic if_en = 1'b1;
  logic fixed_addr_sel = 1'b1;
  logic [6:0] addr_bus = 7'h00;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe, reg_we;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic sda_line;

  logic [7:0] mem [256];
  logic [7:0] model_mem [256];
  logic [7:0] model_ptr;
  logic [15:0] exp_q [$];
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  assign sda_line  = sda_m & ~sda_oe;
  assign reg_rdata = mem[reg_addr];

  i2c_regport_slave uut (
    .clk(clk), .rst_n(rst_n), .if_en(if_en), .fixed_addr_sel(fixed_addr_sel),
    .addr_bus(addr_bus), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
    .reg_rdata(reg_rdata)
  );

  always @(posedge clk) if (reg_we) mem[reg_addr] <= reg_wdata;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // every clock: each write strobe must match the model's next expected write
  always @(negedge clk) begin
    if (rst_n && reg_we) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R5 unexpected write", {reg_addr, reg_wdata}, 0);
      end else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        check({reg_addr, reg_wdata} == e, "R5 write addr/data", {reg_addr, reg_wdata}, e);
      end
    end
  end

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; wq(Q);
    scl_m = 1'b1; wq(Q);
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b1; wq(Q);
    sda_m = 1'b1; wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(Q);
      scl_m = 1'b1; wq(2*Q);
      scl_m = 1'b0; wq(Q);
    end
    sda_m = 1'b1; wq(Q);
    scl_m = 1'b1; wq(Q);
    ack = ~sda_line; wq(Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(Q);
      scl_m = 1'b1; wq(Q);
      b[i] = sda_line; wq(Q);
      scl_m = 1'b0; wq(Q);
    end
    sda_m = ~give_ack; wq(Q);
    scl_m = 1'b1; wq(2*Q);
    scl_m = 1'b0; wq(Q);
    sda_m = 1'b1;
  endtask

  // send a byte and compare the ACK with the expectation
  task automatic put(input logic [7:0] b, input logic exp_ack, input string tag);
    logic a;
    send_byte(b, a);
    check(a == exp_ack, tag, a, exp_ack);
  endtask

  // data byte of a matched write: the model records the expected write
  task automatic put_data(input logic [7:0] b, input string tag);
    exp_q.push_back({model_ptr, b});
    model_mem[model_ptr] = b;
    model_ptr = model_ptr + 8'd1;
    put(b, 1'b1, tag);
  endtask

  task automatic get(input logic give_ack, input string tag);
    logic [7:0] b;
    recv_byte(give_ack, b);
    check(b == model_mem[model_ptr], tag, b, model_mem[model_ptr]);
    model_ptr = model_ptr + 8'd1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'h00;
      model_mem[i] = 8'h00;
    end
    model_ptr = 8'h00;
    wq(5);
    rst_n = 1'b1;
    wq(10);

    // R10: reset state
    check(sda_oe == 1'b0, "R10 sda_oe after reset", sda_oe, 0);
    check(reg_we == 1'b0, "R10 reg_we after reset", reg_we, 0);
    check(reg_addr == 8'h00, "R10 reg_addr after reset", reg_addr, 0);

    // R2 R4 R5 R9: fixed address write, pointer then three data bytes
    bus_start;
    put({7'h5C, 1'b0}, 1'b1, "R2 fixed address ack");
    put(8'h10, 1'b1, "R9 pointer byte ack");
    model_ptr = 8'h10;
    check(reg_addr == 8'h10, "R4 pointer loaded", reg_addr, 8'h10);
    put_data(8'hA1, "R9 data ack");
    put_data(8'hB2, "R9 data ack");
    put_data(8'hC3, "R9 data ack");
    bus_stop;
    wq(4);
    check(reg_addr == model_ptr, "R5 pointer after writes", reg_addr, model_ptr);

    // R6 R7: set pointer, repeated START, read two bytes, NACK the last
    bus_start;
    put({7'h5C, 1'b0}, 1'b1, "R3 address ack");
    put(8'h11, 1'b1, "R9 pointer ack");
    model_ptr = 8'h11;
    bus_start;
    put({7'h5C, 1'b1}, 1'b1, "R7 repeated start address ack");
    get(1'b1, "R6 read byte 0");
    get(1'b0, "R6 read byte 1");
    wq(Q);
    check(sda_oe == 1'b0, "R6 released after NACK", sda_oe, 0);
    bus_stop;
    wq(4);
    check(reg_addr == model_ptr, "R6 pointer after read", reg_addr, model_ptr);

    // R3: mismatched address, no ACK, later byte ignored
    bus_start;
    put({7'h3A, 1'b0}, 1'b0, "R3 mismatch nack");
    put(8'h44, 1'b0, "R3 byte after mismatch nack");
    bus_stop;
    wq(4);
    check(reg_addr == model_ptr, "R3 pointer unchanged", reg_addr, model_ptr);

    // R2: address from the input bus
    fixed_addr_sel = 1'b0;
    addr_bus = 7'h27;
    bus_start;
    put({7'h27, 1'b0}, 1'b1, "R2 bus address ack");
    put(8'h40, 1'b1, "R9 pointer ack");
    model_ptr = 8'h40;
    put_data(8'h99, "R9 data ack");
    bus_stop;
    bus_start;
    put({7'h5C, 1'b0}, 1'b0, "R2 fixed address ignored when bus selected");
    bus_stop;

    // R1: interface disabled
    if_en = 1'b0;
    wq(4);
    bus_start;
    put({7'h27, 1'b0}, 1'b0, "R1 no ack when disabled");
    put(8'h77, 1'b0, "R1 no ack on data when disabled");
    bus_stop;
    wq(4);
    check(reg_addr == model_ptr, "R1 pointer unchanged when disabled", reg_addr, model_ptr);
    if_en = 1'b1;
    wq(4);

    // R4 R7: pointer-only write, then a separate read from it
    bus_start;
    put({7'h27, 1'b0}, 1'b1, "R4 address ack");
    put(8'h12, 1'b1, "R4 pointer ack");
    model_ptr = 8'h12;
    bus_stop;
    wq(4);
    check(reg_addr == 8'h12, "R7 pointer kept after STOP", reg_addr, 8'h12);
    bus_start;
    put({7'h27, 1'b1}, 1'b1, "R6 read address ack");
    get(1'b0, "R4 read at loaded pointer");
    bus_stop;

    // R5: pointer wrap at 8'hFF
    bus_start;
    put({7'h27, 1'b0}, 1'b1, "R5 address ack");
    put(8'hFF, 1'b1, "R5 pointer ack");
    model_ptr = 8'hFF;
    put_data(8'h5A, "R5 write at FF");
    put_data(8'h6B, "R5 write after wrap");
    bus_stop;
    wq(4);
    check(reg_addr == 8'h01, "R5 pointer wrapped", reg_addr, 8'h01);

    // R6: read across the wrap
    bus_start;
    put({7'h27, 1'b0}, 1'b1, "R6 address ack");
    put(8'hFF, 1'b1, "R6 pointer ack");
    model_ptr = 8'hFF;
    bus_start;
    put({7'h27, 1'b1}, 1'b1, "R6 read address ack");
    get(1'b1, "R6 read at FF");
    get(1'b0, "R6 read at 00");
    bus_stop;
    wq(10);

    check(exp_q.size() == 0, "R5 all expected writes seen", exp_q.size(), 0);
    begin
      int bad = 0;
      for (int i = 0; i < 256; i++) if (mem[i] != model_mem[i]) bad++;
      check(bad == 0, "R5 register file contents", bad, 0);
    end

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule